// File: doc/BRIEF.md
# Delta-Timed Event Queue

This block keeps a pool of pending timed events in hardware. Each event carries a short tag. Events sit in a doubly linked list sorted by expiry. Every list entry stores only the gap between its own expiry and the expiry of the entry in front of it. Because of this, deciding whether anything is due takes a single comparison: the head gap against a running accumulator of elapsed cycles.

A client uses the block through three request ports:

- **Schedule** takes a delay and a tag. It returns the handle of the slot that now holds the event.
- **Cancel** takes a handle and withdraws that event. The events behind it keep their absolute expiry times.
- **Advance** reports a number of elapsed cycles. The queue then releases every event that has come due, one tag per clock, in expiry order.

Delays are measured from the queue's reference point. The reference point is the expiry of the last event that fired, or the moment the queue last became empty. Insertion walks the list one entry per clock. While the block is walking, unlinking or firing, it holds a busy flag and accepts no new request.

Top module: `evq_delta_queue`

## Requirements
- R1: After synchronous reset the queue is empty: `busy`, `sch_done` and `fire_valid` are low.
- R2: A schedule request takes the lowest-numbered free slot. Completion shows `sch_done` high for one cycle, with `sch_ok`=1 and `sch_handle` equal to that slot number.
- R3: When every slot is occupied, a schedule request completes with `sch_ok`=0 and `sch_handle`=0. Every queued event still fires exactly as it would have without the request.
- R4: Events fire in order of expiry. Events with the same expiry fire in the order they were scheduled.
- R5: An advance adds `adv_cycles` to the elapsed count. Every event whose delay, measured from the reference point, is at most the elapsed count fires during that advance. No other event fires.
- R6: A cancelled event never fires. Every event queued behind it keeps its original expiry time.
- R7: A cancel naming a slot that holds no event is ignored: the block does not go busy and the firing schedule is unchanged.
- R8: Requests are taken only while `busy` is low; a request presented while `busy` is high is dropped. When several requests arrive in the same idle cycle, schedule wins over cancel, and cancel wins over advance; the losing requests are dropped.
- R9: An advance while the queue is empty is discarded. Whenever the queue becomes empty, the reference point moves to the present, so the next delay counts from there.
- R10: Fired tags appear on `fire_tag` with `fire_valid` high for one cycle each, only while `busy` is high, and at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sch_valid | input | 1 | Schedule request |
| sch_delay | input | DLY_W | Delay of the new event |
| sch_tag | input | TAG_W | Tag of the new event |
| cxl_valid | input | 1 | Cancel request |
| cxl_handle | input | IDX_W | Slot to cancel |
| adv_valid | input | 1 | Advance request |
| adv_cycles | input | ADV_W | Elapsed cycles to add |
| busy | output | 1 | Block is processing a request |
| sch_done | output | 1 | Schedule request finished (one cycle) |
| sch_ok | output | 1 | Schedule succeeded |
| sch_handle | output | IDX_W | Slot used by the new event (0 on failure) |
| fire_valid | output | 1 | A tag fired this cycle |
| fire_tag | output | TAG_W | Tag of the fired event |

## Verification
The bench builds the queue with DEPTH=4, TAG_W=4, DLY_W=6 and ADV_W=4. With only four slots, a few requests fill the pool, so the full-pool refusal and lowest-free-slot reuse come up over and over. The short delay and advance ranges produce equal expiry times, zero delays and multi-event firing bursts often. A long mixed sweep of schedules, cancels (to live and dead handles) and advances is checked against an arithmetic model of absolute expiry times. That sweep covers ordering, tie-breaking, cancellation fix-ups and the reset of the reference point when the queue empties.

// File: rtl/evq_pkg.sv
package evq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_UNLINK,
        ST_FIRE
    } evq_state_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_SCHED,
        REQ_CANCEL,
        REQ_ADV
    } evq_req_e;

    // Fixed priority between simultaneous requests: schedule, cancel, advance.
    function automatic evq_req_e pick_req(input logic s, input logic c, input logic a);
        if (s)      return REQ_SCHED;
        else if (c) return REQ_CANCEL;
        else if (a) return REQ_ADV;
        else        return REQ_NONE;
    endfunction

endpackage

// File: rtl/evq_free_finder.sv
module evq_free_finder #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] used,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scanning from the top down leaves the lowest free slot as the result.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/evq_walk_step.sv
module evq_walk_step #(
    parameter int DLY_W = 16
) (
    input  logic             cur_ok,
    input  logic [DLY_W-1:0] cur_dlt,
    input  logic [DLY_W-1:0] rem,
    output logic             stop,
    output logic [DLY_W-1:0] rem_next
);
    // Stop in front of the first entry whose gap is strictly larger than
    // the remaining delay, or at the end of the list.
    assign stop     = !cur_ok || (cur_dlt > rem);
    assign rem_next = rem - cur_dlt;
endmodule

// File: rtl/evq_fire_check.sv
module evq_fire_check #(
    parameter int DLY_W = 16,
    parameter int ACC_W = 17
) (
    input  logic             head_ok,
    input  logic [DLY_W-1:0] head_dlt,
    input  logic [ACC_W-1:0] acc,
    output logic             due,
    output logic [ACC_W-1:0] acc_next
);
    logic [ACC_W-1:0] dlt_ext;

    assign dlt_ext  = ACC_W'(head_dlt);
    assign due      = head_ok && (dlt_ext <= acc);
    assign acc_next = acc - dlt_ext;
endmodule

// File: rtl/evq_delta_queue.sv
module evq_delta_queue
    import evq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TAG_W = 8,
    parameter int DLY_W = 16,
    parameter int ADV_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int ACC_W = ((DLY_W > ADV_W) ? DLY_W : ADV_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sch_valid,
    input  logic [DLY_W-1:0] sch_delay,
    input  logic [TAG_W-1:0] sch_tag,
    input  logic             cxl_valid,
    input  logic [IDX_W-1:0] cxl_handle,
    input  logic             adv_valid,
    input  logic [ADV_W-1:0] adv_cycles,
    output logic             busy,
    output logic             sch_done,
    output logic             sch_ok,
    output logic [IDX_W-1:0] sch_handle,
    output logic             fire_valid,
    output logic [TAG_W-1:0] fire_tag
);

    typedef struct packed {
        logic             vld;
        logic [DLY_W-1:0] dlt;
        logic [TAG_W-1:0] tag;
        logic             has_prv;
        logic [IDX_W-1:0] prv;
        logic             has_nxt;
        logic [IDX_W-1:0] nxt;
    } slot_t;

    slot_t            slots [DEPTH];
    evq_state_e       state;
    logic [IDX_W-1:0] head;
    logic             head_ok;
    logic [ACC_W-1:0] acc;

    // Insertion walk registers
    logic [IDX_W-1:0] new_slot;
    logic [TAG_W-1:0] new_tag;
    logic [DLY_W-1:0] rem;
    logic [IDX_W-1:0] cur;
    logic             cur_ok;
    logic [IDX_W-1:0] prv;
    logic             prv_ok;
    logic [IDX_W-1:0] cx;

    logic [DEPTH-1:0] used_vec;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             walk_stop;
    logic [DLY_W-1:0] walk_rem_next;
    logic             fire_due;
    logic [ACC_W-1:0] fire_acc_next;
    slot_t            cur_ent, cx_ent, hd_ent;
    evq_req_e         req;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_used
            assign used_vec[g] = slots[g].vld;
        end
    endgenerate

    assign cur_ent = slots[cur];
    assign cx_ent  = slots[cx];
    assign hd_ent  = slots[head];
    assign busy    = (state != ST_IDLE);
    assign req     = pick_req(sch_valid, cxl_valid, adv_valid);

    evq_free_finder #(.DEPTH(DEPTH)) u_free (
        .used  (used_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    evq_walk_step #(.DLY_W(DLY_W)) u_walk (
        .cur_ok   (cur_ok),
        .cur_dlt  (cur_ent.dlt),
        .rem      (rem),
        .stop     (walk_stop),
        .rem_next (walk_rem_next)
    );

    evq_fire_check #(.DLY_W(DLY_W), .ACC_W(ACC_W)) u_fire (
        .head_ok  (head_ok),
        .head_dlt (hd_ent.dlt),
        .acc      (acc),
        .due      (fire_due),
        .acc_next (fire_acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
            state      <= ST_IDLE;
            head       <= '0;
            head_ok    <= 1'b0;
            acc        <= '0;
            new_slot   <= '0;
            new_tag    <= '0;
            rem        <= '0;
            cur        <= '0;
            cur_ok     <= 1'b0;
            prv        <= '0;
            prv_ok     <= 1'b0;
            cx         <= '0;
            sch_done   <= 1'b0;
            sch_ok     <= 1'b0;
            sch_handle <= '0;
            fire_valid <= 1'b0;
            fire_tag   <= '0;
        end else begin
            sch_done   <= 1'b0;
            fire_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    unique case (req)
                        REQ_SCHED: begin
                            if (free_found) begin
                                new_slot <= free_idx;
                                new_tag  <= sch_tag;
                                rem      <= sch_delay;
                                cur      <= head;
                                cur_ok   <= head_ok;
                                prv      <= '0;
                                prv_ok   <= 1'b0;
                                state    <= ST_WALK;
                            end else begin
                                sch_done   <= 1'b1;
                                sch_ok     <= 1'b0;
                                sch_handle <= '0;
                            end
                        end
                        REQ_CANCEL: begin
                            if (slots[cxl_handle].vld) begin
                                cx    <= cxl_handle;
                                state <= ST_UNLINK;
                            end
                        end
                        REQ_ADV: begin
                            if (head_ok) begin
                                acc   <= acc + ACC_W'(adv_cycles);
                                state <= ST_FIRE;
                            end
                        end
                        default: ;
                    endcase
                end

                ST_WALK: begin
                    if (walk_stop) begin
                        slots[new_slot].vld     <= 1'b1;
                        slots[new_slot].dlt     <= rem;
                        slots[new_slot].tag     <= new_tag;
                        slots[new_slot].has_prv <= prv_ok;
                        slots[new_slot].prv     <= prv;
                        slots[new_slot].has_nxt <= cur_ok;
                        slots[new_slot].nxt     <= cur;
                        if (prv_ok) begin
                            slots[prv].nxt     <= new_slot;
                            slots[prv].has_nxt <= 1'b1;
                        end else begin
                            head    <= new_slot;
                            head_ok <= 1'b1;
                        end
                        if (cur_ok) begin
                            slots[cur].prv     <= new_slot;
                            slots[cur].has_prv <= 1'b1;
                            slots[cur].dlt     <= cur_ent.dlt - rem;
                        end
                        sch_done   <= 1'b1;
                        sch_ok     <= 1'b1;
                        sch_handle <= new_slot;
                        state      <= ST_IDLE;
                    end else begin
                        rem    <= walk_rem_next;
                        prv    <= cur;
                        prv_ok <= 1'b1;
                        cur    <= cur_ent.nxt;
                        cur_ok <= cur_ent.has_nxt;
                    end
                end

                ST_UNLINK: begin
                    slots[cx].vld <= 1'b0;
                    if (cx_ent.has_prv) begin
                        slots[cx_ent.prv].nxt     <= cx_ent.nxt;
                        slots[cx_ent.prv].has_nxt <= cx_ent.has_nxt;
                    end else begin
                        head    <= cx_ent.nxt;
                        head_ok <= cx_ent.has_nxt;
                    end
                    if (cx_ent.has_nxt) begin
                        slots[cx_ent.nxt].prv     <= cx_ent.prv;
                        slots[cx_ent.nxt].has_prv <= cx_ent.has_prv;
                        slots[cx_ent.nxt].dlt     <= slots[cx_ent.nxt].dlt + cx_ent.dlt;
                    end
                    if (!cx_ent.has_prv && !cx_ent.has_nxt) acc <= '0;
                    state <= ST_IDLE;
                end

                ST_FIRE: begin
                    if (fire_due) begin
                        fire_valid        <= 1'b1;
                        fire_tag          <= hd_ent.tag;
                        slots[head].vld   <= 1'b0;
                        head              <= hd_ent.nxt;
                        head_ok           <= hd_ent.has_nxt;
                        if (hd_ent.has_nxt) begin
                            slots[hd_ent.nxt].has_prv <= 1'b0;
                            acc <= fire_acc_next;
                        end else begin
                            acc <= '0;
                        end
                    end else begin
                        state <= ST_IDLE;
                    end
                end

                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/evq_checker.sv
module evq_checker #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             sch_valid,
    input logic             busy,
    input logic             sch_done,
    input logic             sch_ok,
    input logic [IDX_W-1:0] sch_handle,
    input logic             fire_valid
);
    AST_FIRE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        fire_valid |-> busy); // R10

    AST_NO_FIRE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !fire_valid); // R10

    AST_FELL_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !fire_valid); // R10

    AST_FAIL_NO_HANDLE: assert property (@(posedge clk) disable iff (rst)
        (sch_done && !sch_ok) |-> (sch_handle == '0)); // R3

    AST_FAIL_FROM_REQUEST: assert property (@(posedge clk) disable iff (rst)
        (sch_done && !sch_ok) |-> $past(sch_valid)); // R3

    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (rst)
        sch_done |-> !busy); // R8
endmodule

bind evq_delta_queue evq_checker #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sch_valid  (sch_valid),
    .busy       (busy),
    .sch_done   (sch_done),
    .sch_ok     (sch_ok),
    .sch_handle (sch_handle),
    .fire_valid (fire_valid)
);

// File: tb/evq_delta_queue_test.sv
`timescale 1ns/1ps
module evq_delta_queue_test;
    localparam int DEPTH = 4;
    localparam int TAG_W = 4;
    localparam int DLY_W = 6;
    localparam int ADV_W = 4;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sch_valid = 1'b0;
    logic [DLY_W-1:0] sch_delay = '0;
    logic [TAG_W-1:0] sch_tag = '0;
    logic             cxl_valid = 1'b0;
    logic [IDX_W-1:0] cxl_handle = '0;
    logic             adv_valid = 1'b0;
    logic [ADV_W-1:0] adv_cycles = '0;
    logic             busy, sch_done, sch_ok, fire_valid;
    logic [IDX_W-1:0] sch_handle;
    logic [TAG_W-1:0] fire_tag;

    always #2.5 clk = ~clk;

    evq_delta_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DLY_W(DLY_W), .ADV_W(ADV_W)) uut (
        .clk(clk), .rst(rst),
        .sch_valid(sch_valid), .sch_delay(sch_delay), .sch_tag(sch_tag),
        .cxl_valid(cxl_valid), .cxl_handle(cxl_handle),
        .adv_valid(adv_valid), .adv_cycles(adv_cycles),
        .busy(busy), .sch_done(sch_done), .sch_ok(sch_ok), .sch_handle(sch_handle),
        .fire_valid(fire_valid), .fire_tag(fire_tag)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit wd_hit = 1'b0;

    // Reference model: absolute expiry times
    bit      m_vld [DEPTH];
    longint  m_exp [DEPTH];
    int      m_seq [DEPTH];
    int      m_tag [DEPTH];
    longint  now_t = 0;
    longint  ref_t = 0;
    int      seq_ctr = 0;

    task automatic check(input string req, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int m_live();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (m_vld[i]) n++;
        return n;
    endfunction

    function automatic int m_lowest_free();
        for (int i = 0; i < DEPTH; i++) if (!m_vld[i]) return i;
        return -1;
    endfunction

    task automatic m_insert(input int h, input int d, input int tag);
        m_vld[h] = 1'b1;
        m_exp[h] = ref_t + d;
        m_seq[h] = seq_ctr++;
        m_tag[h] = tag;
    endtask

    task automatic wait_idle();
        while (busy && !wd_hit) @(negedge clk);
    endtask

    // R2 / R3: schedule and compare handle and status with the model
    task automatic do_sched(input int d, input int tag, input string req);
        int exp_h = m_lowest_free();
        @(negedge clk);
        sch_valid = 1'b1; sch_delay = DLY_W'(d); sch_tag = TAG_W'(tag);
        @(negedge clk);
        sch_valid = 1'b0;
        while (!sch_done && !wd_hit) @(negedge clk);
        if (exp_h < 0) begin
            check(req, "sch_ok on full pool", sch_ok, 0);
            check(req, "handle on full pool", sch_handle, 0);
        end else begin
            check(req, "sch_ok", sch_ok, 1);
            check(req, "handle", sch_handle, exp_h);
            m_insert(exp_h, d, tag);
        end
    endtask

    task automatic m_cancel(input int h);
        if (m_vld[h]) begin
            m_vld[h] = 1'b0;
            if (m_live() == 0) ref_t = now_t;
        end
    endtask

    task automatic do_cancel(input int h);
        bit was_live = m_vld[h];
        @(negedge clk);
        cxl_valid = 1'b1; cxl_handle = IDX_W'(h);
        @(negedge clk);
        cxl_valid = 1'b0;
        if (!was_live) check("R7", "busy after dead cancel", busy, 0);
        m_cancel(h);
        wait_idle();
    endtask

    // R4 / R5: advance and compare the fired tag stream with the model
    task automatic do_adv(input int n, input string req);
        int exp_tags [DEPTH];
        int exp_n = 0;
        int got_tags [DEPTH + 1];
        int got_n = 0;
        if (m_live() > 0) begin
            now_t += n;
            forever begin
                int best = -1;
                for (int i = 0; i < DEPTH; i++) begin
                    if (m_vld[i] && m_exp[i] <= now_t) begin
                        if (best < 0 || m_exp[i] < m_exp[best] ||
                            (m_exp[i] == m_exp[best] && m_seq[i] < m_seq[best])) best = i;
                    end
                end
                if (best < 0) break;
                exp_tags[exp_n++] = m_tag[best];
                ref_t = m_exp[best];
                m_vld[best] = 1'b0;
            end
            if (m_live() == 0) ref_t = now_t;
        end
        @(negedge clk);
        adv_valid = 1'b1; adv_cycles = ADV_W'(n);
        @(negedge clk);
        adv_valid = 1'b0;
        forever begin
            if (fire_valid && got_n <= DEPTH) got_tags[got_n++] = int'(fire_tag);
            if (!busy || wd_hit) break;
            @(negedge clk);
        end
        check(req, "fired count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(req, "fired tag order", got_tags[i], exp_tags[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            wd_hit = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", busy, 0);
        check("R1", "sch_done", sch_done, 0);
        check("R1", "fire_valid", fire_valid, 0);

        // R9: advance on an empty queue is discarded
        do_adv(9, "R9");
        do_sched(3, 1, "R9");
        do_adv(2, "R9");
        do_adv(1, "R9");

        // R2: fill the pool, lowest free slot each time
        do_sched(20, 2, "R2");
        do_sched(5, 3, "R2");
        do_sched(20, 4, "R2");
        do_sched(12, 5, "R2");
        // R3: full pool refuses
        do_sched(1, 6, "R3");
        // R4: ties fire in schedule order; R5 partial advance
        do_adv(4, "R5");
        do_adv(8, "R5");
        do_adv(8, "R4");

        // R6: cancel middle entry, later events keep expiry
        do_sched(10, 7, "R6");
        do_sched(15, 8, "R6");
        do_sched(25, 9, "R6");
        do_cancel(1);
        do_adv(14, "R6");
        do_adv(1, "R6");
        // R7: cancel a dead slot
        do_cancel(1);
        do_adv(10, "R7");

        // R8: request during busy is dropped
        do_sched(30, 10, "R8");
        do_sched(40, 11, "R8");
        @(negedge clk);
        cxl_valid = 1'b1; cxl_handle = IDX_W'(m_lowest_free() == 0 ? 1 : 0);
        @(negedge clk);
        cxl_valid = 1'b0;
        m_cancel(int'(cxl_handle));
        sch_valid = 1'b1; sch_delay = 6'd1; sch_tag = 4'd12;
        @(negedge clk);
        sch_valid = 1'b0;
        repeat (3) begin
            check("R8", "sch_done for dropped request", sch_done, 0);
            @(negedge clk);
        end
        // R8: simultaneous schedule and cancel, schedule wins
        begin
            int exp_h = m_lowest_free();
            int victim = -1;
            for (int i = DEPTH - 1; i >= 0; i--) if (m_vld[i]) victim = i;
            @(negedge clk);
            sch_valid = 1'b1; sch_delay = 6'd2; sch_tag = 4'd13;
            cxl_valid = 1'b1; cxl_handle = IDX_W'(victim < 0 ? 0 : victim);
            @(negedge clk);
            sch_valid = 1'b0; cxl_valid = 1'b0;
            while (!sch_done && !wd_hit) @(negedge clk);
            check("R8", "priority sch_ok", sch_ok, 1);
            check("R8", "priority handle", sch_handle, exp_h);
            m_insert(exp_h, 2, 13);
        end
        do_adv(15, "R8");
        do_adv(15, "R8");
        do_adv(15, "R8");

        // R10 and sweep: mixed random operations
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 4);
            if (op == 0 || op == 1) do_sched(int'($urandom % 64), int'($urandom % 16), "R4");
            else if (op == 2) do_cancel(int'($urandom % DEPTH));
            else do_adv(int'($urandom % 16), "R5");
            if (wd_hit) break;
        end
        // drain
        for (int k = 0; k < 8; k++) do_adv(15, "R10");
        check("R9", "busy when drained", busy, 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule